// File: doc/BRIEF.md
# Oversampled Asynchronous Character Receiver

This block turns a single asynchronous serial line into parallel characters. The line is sampled on an oversampling enable that pulses sixteen times per bit. A falling edge on an idle line starts a character, and the block checks that the line is still low at mid-bit before it accepts the edge as a start bit. It then takes 5 to 8 data bits, an optional parity bit and the first stop bit at mid-bit. For each completed character it raises a one-cycle valid strobe, together with the data and three error flags, so that a buffer behind it can store the character.

The character format comes from line-control inputs. These inputs are captured when a start edge is detected and held until that character is finished. A loopback select routes an internal transmit line into the receiver in place of the pin. When the stop bit is low the block reports a framing error and takes that low bit as the start of the next character. A line held low for a whole character is reported as a break: the block delivers one all-zero character and then stays silent until the line goes high again.

Top module: `serial_char_rx`

## Requirements
- R1: After reset char_valid, char_data and all error flags are 0, and an idle line that stays high produces no character.
- R2: The word-length code selects the number of data bits: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. The first data bit received is char_data[0], and char_data bits above the word length read as 0.
- R3: With par_en=1 and par_stick=0, par_even=1 expects an even number of ones across the data bits and the parity bit, and par_even=0 expects an odd number. A mismatch sets err_parity with the character.
- R4: With par_en=1 and par_stick=1, the parity bit is expected to be 0 when par_even=1 and 1 when par_even=0. Any other value sets err_parity.
- R5: With par_en=0 no parity bit is taken, and err_parity is always 0.
- R6: Only the first stop bit is examined. A new start bit that directly follows a single high stop bit is received as a new character.
- R7: A low first stop bit sets err_frame. That low bit is then taken as the start bit of the next character, whose data bits follow at once.
- R8: When the line stays low through the stop-bit position of a character whose data and parity bits are all 0, the block delivers exactly one character with char_data=0, err_break=1, err_frame=1 and err_parity=0. No further character follows until the line has gone high and a new start bit arrives.
- R9: A low pulse that has ended by the mid-point of the start bit is treated as a false start and produces no character.
- R10: With loop_en=1 the receiver takes its input from loop_line and ignores rx_pin. With loop_en=0 it uses rx_pin.
- R11: char_valid is high for exactly one clock for each character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling enable, sixteen pulses per bit |
| rx_pin | input | 1 | Serial input from the pin |
| loop_en | input | 1 | Select loop_line as the receiver input |
| loop_line | input | 1 | Internal transmit line used in loopback |
| wlen | input | 2 | Word-length code |
| par_en | input | 1 | Parity bit present and checked |
| par_even | input | 1 | Even parity select (stick value select when par_stick=1) |
| par_stick | input | 1 | Stick parity enable |
| char_valid | output | 1 | One-cycle strobe for a completed character |
| char_data | output | 8 | Received character, right-aligned |
| err_parity | output | 1 | Parity error for this character |
| err_frame | output | 1 | First stop bit was low |
| err_break | output | 1 | Character is a break indication |

## Verification
A bit counter or oversampling phase that is off by one shows at the ports within one character. The data comes out shifted, the mask on the upper bits is wrong, or a framing error is reported on a clean frame. A parity state that is wrong corrupts err_parity on the very next character that has parity enabled. A resynchronisation or break state that is wrong shows in the character count: the character after a framing error is lost, or a held-low line produces more than one character. The bench counts strobes over each window of stimulus for this reason.

// File: rtl/rx_pkg.sv
package rx_pkg;
   localparam int unsigned RX_DW = 8;

   typedef enum logic [2:0] {
      S_IDLE,
      S_START,
      S_DATA,
      S_PAR,
      S_STOP,
      S_BRK
   } rx_state_e;

   typedef struct packed {
      logic [1:0] wlen;
      logic       pen;
      logic       peven;
      logic       pstick;
   } rx_fmt_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[0] <= 1'b1;
            else        chain[0] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[i] <= 1'b1;
            else        chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_parity_chk.sv
module rx_parity_chk #(
   parameter int unsigned DW = 8
) (
   input  logic [DW-1:0] data,
   input  logic          pen,
   input  logic          peven,
   input  logic          pstick,
   input  logic          pbit,
   output logic          err
);
   always_comb begin
      if (!pen)        err = 1'b0;
      else if (pstick) err = (pbit != !peven);
      else             err = ((^data) ^ pbit) != !peven;
   end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
   import rx_pkg::*;
#(
   parameter int unsigned OSR       = 16,
   parameter int unsigned SAMPLE_PT = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            rx_s,
   input  rx_fmt_t         fmt_in,
   output logic            valid,
   output logic [RX_DW-1:0] data,
   output logic            perr,
   output logic            ferr,
   output logic            brk
);
   localparam int unsigned CW = $clog2(OSR);
   localparam int unsigned BW = $clog2(RX_DW);
   localparam int unsigned NW = BW + 1;

   if (OSR < 4) begin : g_bad_osr
      $error("rx_frame_fsm: OSR must be at least 4");
   end
   if (SAMPLE_PT < 1 || SAMPLE_PT >= OSR) begin : g_bad_pt
      $error("rx_frame_fsm: SAMPLE_PT must lie inside the bit");
   end

   rx_state_e        state;
   logic [CW-1:0]    cnt;
   logic [BW-1:0]    bitn;
   logic [RX_DW-1:0] sh;
   logic             pbit;
   rx_fmt_t          fmt_q;
   logic [NW-1:0]    nbits;
   logic [RX_DW-1:0] aligned;
   logic             par_bad;
   logic             all_low;
   logic             bit_end;

   assign nbits   = NW'(RX_DW - 3) + NW'(fmt_q.wlen);
   assign aligned = sh >> (NW'(RX_DW) - nbits);
   assign all_low = (aligned == '0) && (!fmt_q.pen || !pbit) && !rx_s;
   assign bit_end = tick && (cnt == CW'(OSR - 1));

   rx_parity_chk #(.DW(RX_DW)) i_par (
      .data  (aligned),
      .pen   (fmt_q.pen),
      .peven (fmt_q.peven),
      .pstick(fmt_q.pstick),
      .pbit  (pbit),
      .err   (par_bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         cnt   <= '0;
         bitn  <= '0;
         sh    <= '0;
         pbit  <= 1'b0;
         fmt_q <= '0;
         valid <= 1'b0;
         data  <= '0;
         perr  <= 1'b0;
         ferr  <= 1'b0;
         brk   <= 1'b0;
      end else begin
         valid <= 1'b0;
         case (state)
            S_IDLE: if (tick && !rx_s) begin
               state <= S_START;
               cnt   <= '0;
               bitn  <= '0;
               sh    <= '0;
               fmt_q <= fmt_in;
            end
            S_START: if (tick) begin
               if (cnt == CW'(SAMPLE_PT - 1)) begin
                  cnt   <= '0;
                  state <= rx_s ? S_IDLE : S_DATA;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            S_DATA: if (bit_end) begin
               cnt <= '0;
               sh  <= {rx_s, sh[RX_DW-1:1]};
               if (NW'(bitn) == nbits - 1'b1)
                  state <= fmt_q.pen ? S_PAR : S_STOP;
               else
                  bitn <= bitn + 1'b1;
            end else if (tick) begin
               cnt <= cnt + 1'b1;
            end
            S_PAR: if (bit_end) begin
               cnt   <= '0;
               pbit  <= rx_s;
               state <= S_STOP;
            end else if (tick) begin
               cnt <= cnt + 1'b1;
            end
            S_STOP: if (bit_end) begin
               cnt   <= '0;
               valid <= 1'b1;
               if (rx_s) begin
                  data  <= aligned;
                  perr  <= par_bad;
                  ferr  <= 1'b0;
                  brk   <= 1'b0;
                  state <= S_IDLE;
               end else if (all_low) begin
                  data  <= '0;
                  perr  <= 1'b0;
                  ferr  <= 1'b1;
                  brk   <= 1'b1;
                  state <= S_BRK;
               end else begin
                  data  <= aligned;
                  perr  <= par_bad;
                  ferr  <= 1'b1;
                  brk   <= 1'b0;
                  bitn  <= '0;
                  sh    <= '0;
                  state <= S_DATA;
               end
            end else if (tick) begin
               cnt <= cnt + 1'b1;
            end
            S_BRK: if (rx_s) state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   // R11
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);
   // R8
   brk_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && brk) |-> (data == '0 && ferr && !perr));
   // R8
   brk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_BRK && $past(state == S_BRK)) |-> !valid);
   // R2
   width_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> ((data >> nbits) == '0));
   // R5
   noparity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !fmt_q.pen) |-> !perr);
endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx
   import rx_pkg::*;
#(
   parameter int unsigned OSR         = 16,
   parameter int unsigned SAMPLE_PT   = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick16,
   input  logic       rx_pin,
   input  logic       loop_en,
   input  logic       loop_line,
   input  logic [1:0] wlen,
   input  logic       par_en,
   input  logic       par_even,
   input  logic       par_stick,
   output logic       char_valid,
   output logic [7:0] char_data,
   output logic       err_parity,
   output logic       err_frame,
   output logic       err_break
);
   logic    line_raw;
   logic    line_s;
   rx_fmt_t fmt;

   assign line_raw = loop_en ? loop_line : rx_pin;
   assign fmt      = '{wlen: wlen, pen: par_en, peven: par_even, pstick: par_stick};

   rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (line_raw),
      .q    (line_s)
   );

   rx_frame_fsm #(.OSR(OSR), .SAMPLE_PT(SAMPLE_PT)) i_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick16),
      .rx_s  (line_s),
      .fmt_in(fmt),
      .valid (char_valid),
      .data  (char_data),
      .perr  (err_parity),
      .ferr  (err_frame),
      .brk   (err_break)
   );
endmodule

// File: tb/test_serial_char_rx.sv
module test_serial_char_rx;
   localparam int CLK_PERIOD = 10;
   localparam int BITCLK     = 16;
   localparam int NVEC       = 13;

   // {wlen[1:0], pen, peven, pstick, flip, data[7:0]}
   localparam logic [13:0] VEC [NVEC] = '{
      {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
      {2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h1F},
      {2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF},
      {2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 8'h55},
      {2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 8'h3C},
      {2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 8'h3C},
      {2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 8'h81},
      {2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 8'h12},
      {2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 8'hF0},
      {2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 8'h0F},
      {2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 8'h0F},
      {2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 8'h15},
      {2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 8'h66}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b1;
   logic       rx_pin = 1'b1;
   logic       loop_en = 1'b0;
   logic       loop_line = 1'b1;
   logic [1:0] wlen = 2'b11;
   logic       par_en = 1'b0;
   logic       par_even = 1'b0;
   logic       par_stick = 1'b0;
   logic       char_valid;
   logic [7:0] char_data;
   logic       err_parity, err_frame, err_break;

   int   n_checks = 0;
   int   n_fail = 0;
   int   vcount = 0;
   logic prev_valid = 1'b0;
   logic [7:0] cap_data [4];
   logic [2:0] cap_flags [4];

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_char_rx i_serial_char_rx (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_pin(rx_pin),
      .loop_en(loop_en), .loop_line(loop_line), .wlen(wlen),
      .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
      .char_valid(char_valid), .char_data(char_data),
      .err_parity(err_parity), .err_frame(err_frame), .err_break(err_break)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (char_valid) begin
         if (vcount < 4) begin
            cap_data[vcount]  = char_data;
            cap_flags[vcount] = {err_break, err_frame, err_parity};
         end
         vcount++;
         if (prev_valid) check(1'b0, "R11 valid width", 2, 1);
      end
      prev_valid = char_valid;
   end

   task automatic send_bit(input logic v, input bit use_loop);
      if (use_loop) loop_line = v; else rx_pin = v;
      repeat (BITCLK) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] d, input int nb, input bit pen,
                             input logic pb, input logic stopv, input bit use_loop);
      send_bit(1'b0, use_loop);
      for (int i = 0; i < nb; i++) send_bit(d[i], use_loop);
      if (pen) send_bit(pb, use_loop);
      send_bit(stopv, use_loop);
   endtask

   task automatic idle(input int bits);
      rx_pin = 1'b1;
      loop_line = 1'b1;
      repeat (bits * BITCLK) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      check(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      check(char_valid == 0 && char_data == 0 && err_parity == 0 && err_frame == 0 && err_break == 0,
            "R1 reset outputs", {char_valid, char_data}, 0);
      rst_n = 1'b1;
      idle(4);
      check(vcount == 0, "R1 idle line", vcount, 0);

      // Table: R2 R3 R4 R5
      for (int k = 0; k < NVEC; k++) begin
         logic [7:0] d, m;
         logic       pb, flip;
         int         nb;
         {wlen, par_en, par_even, par_stick, flip, d} = VEC[k];
         nb = 5 + int'(wlen);
         m  = 8'((9'h1 << nb) - 1);
         if (par_stick)     pb = !par_even;
         else if (par_even) pb = ^(d & m);
         else               pb = ~^(d & m);
         pb = pb ^ flip;
         vcount = 0;
         send_frame(d, nb, par_en, pb, 1'b1, 1'b0);
         idle(2);
         check(vcount == 1 && cap_data[0] == (d & m) &&
               cap_flags[0] == {2'b00, par_en & flip},
               "R2/R3/R4/R5 vector", {vcount[3:0], cap_flags[0], cap_data[0]},
               {4'd1, 2'b00, par_en & flip, d & m});
      end

      // R6: back-to-back frames with one stop bit
      wlen = 2'b11; par_en = 1'b0; par_stick = 1'b0;
      vcount = 0;
      send_frame(8'h3A, 8, 1'b0, 1'b0, 1'b1, 1'b0);
      send_frame(8'hC5, 8, 1'b0, 1'b0, 1'b1, 1'b0);
      idle(2);
      check(vcount == 2 && cap_data[0] == 8'h3A && cap_data[1] == 8'hC5,
            "R6 back-to-back", {vcount[7:0], cap_data[1]}, {8'd2, 8'hC5});

      // R7: framing error, low stop bit reused as next start
      vcount = 0;
      send_frame(8'h5B, 8, 1'b0, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 8; i++) send_bit(8'hA7 >> i & 1, 1'b0);
      send_bit(1'b1, 1'b0);
      idle(2);
      check(vcount == 2 && cap_data[0] == 8'h5B && cap_flags[0] == 3'b010,
            "R7 frame error flagged", {cap_flags[0], cap_data[0]}, {3'b010, 8'h5B});
      check(cap_data[1] == 8'hA7 && cap_flags[1] == 3'b000,
            "R7 resync character", {cap_flags[1], cap_data[1]}, {3'b000, 8'hA7});

      // R8: break, line low for many characters
      vcount = 0;
      rx_pin = 1'b0;
      repeat (30 * BITCLK) @(negedge clk);
      check(vcount == 1 && cap_data[0] == 0 && cap_flags[0] == 3'b110,
            "R8 single break char", {vcount[3:0], cap_flags[0], cap_data[0]}, {4'd1, 3'b110, 8'h00});
      idle(2);
      check(vcount == 1, "R8 no char on release", vcount, 1);
      send_frame(8'h42, 8, 1'b0, 1'b0, 1'b1, 1'b0);
      idle(2);
      check(vcount == 2 && cap_data[1] == 8'h42 && cap_flags[1] == 0,
            "R8 resume after break", {vcount[3:0], cap_data[1]}, {4'd2, 8'h42});

      // R9: false start
      vcount = 0;
      rx_pin = 1'b0;
      repeat (4) @(negedge clk);
      idle(12);
      check(vcount == 0, "R9 false start", vcount, 0);
      send_frame(8'h99, 8, 1'b0, 1'b0, 1'b1, 1'b0);
      idle(2);
      check(vcount == 1 && cap_data[0] == 8'h99, "R9 good after false", cap_data[0], 8'h99);

      // R10: loopback
      loop_en = 1'b1;
      vcount = 0;
      send_frame(8'h6E, 8, 1'b0, 1'b0, 1'b1, 1'b1);
      idle(2);
      check(vcount == 1 && cap_data[0] == 8'h6E, "R10 loop input", cap_data[0], 8'h6E);
      vcount = 0;
      send_frame(8'h11, 8, 1'b0, 1'b0, 1'b1, 1'b0);
      idle(2);
      check(vcount == 0, "R10 pin ignored in loop", vcount, 0);
      loop_en = 1'b0;

      // R11: strobe width also watched by monitor; confirm count
      vcount = 0;
      send_frame(8'hE1, 8, 1'b0, 1'b0, 1'b1, 1'b0);
      idle(2);
      check(vcount == 1, "R11 one strobe per char", vcount, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule